// File: doc/BRIEF.md
# Dual-Mode Host Bus Port

This block is the host-facing port of a larger switching device. A processor reaches the device's internal registers and memories through a 16-bit data bus, a 16-bit address, an active-low select and an active-low strobe, plus a read/write line. A static strap chooses one of two bus timings. In synchronous timing, two active-low byte-lane enables choose which bytes take part in an access. In asynchronous timing, the low-lane enable is held low by the board. The high-lane pin then changes role: it becomes an active-low transfer acknowledge that the port drives.

All pins are sampled into the device clock domain by one register stage. Once select and strobe have both been seen low, a fixed number of clocks pass before the access takes effect. At that point a write is stored once, or read data is placed on the bus. In asynchronous timing the acknowledge goes low at the same time. When the host lifts the strobe, the data drivers switch off. The acknowledge is then driven high for one clock and released. The storage behind the port is modelled as a byte-lane register array. An address beyond its depth reads as zero and ignores writes.

Top module: `hbi_host_port`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `dout_oe` is 2'b00 and `ack_oe` is 0.
- R2: An access starts only when `cs_n` and `ds_n` are both low at a sampling edge. With either one high, no write is stored, no data is driven and no acknowledge is given.
- R3: An access that stays selected reaches its active phase on the ACK_DLY+2-th rising edge after both inputs are first driven low. It is not active earlier. With the default ACK_DLY=3, that is the 5th edge.
- R4: In the active phase of a read, `dout` carries the stored word at `addr`. `dout_oe[0]` gates bits 7:0 and `dout_oe[1]` gates bits 15:8.
- R5: With `async_mode`=0, `lbe_n` low enables lane 0 and `hbe_n` low enables lane 1. A read drives only the enabled lanes, and a write updates only the enabled bytes.
- R6: With `async_mode`=1, both lanes take part in every access. During the active phase, `ack_oe`=1 and `ack_n_out`=0.
- R7: In asynchronous timing, the rising edge after the active phase ends (the second edge after select or strobe goes high) starts one cycle with `ack_oe`=1 and `ack_n_out`=1. On the next cycle `ack_oe` returns to 0.
- R8: A write never drives the data bus. With `async_mode`=0, `ack_oe` stays 0.
- R9: With DEPTH=64, an address of 64 or more reads as 0x0000 and its write changes no stored word. This includes the word that shares its low six bits.
- R10: If select or strobe goes high before the active phase, the access is dropped. No write is stored and no acknowledge is given.
- R11: A completed write stores its data exactly once, and a later read at that address returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst | input | 1 | Synchronous reset, active high |
| async_mode | input | 1 | Bus timing strap: 1 asynchronous, 0 synchronous |
| cs_n | input | 1 | Chip select, active low |
| ds_n | input | 1 | Data strobe, active low |
| rd_nwr | input | 1 | 1 read, 0 write |
| addr | input | 16 | Word address |
| din | input | 16 | Write data from the host bus |
| lbe_n | input | 1 | Low-lane enable, active low (tied low in asynchronous timing) |
| hbe_n | input | 1 | High-lane enable, active low, from the shared pin (synchronous timing) |
| dout | output | 16 | Read data toward the host bus |
| dout_oe | output | 2 | Per-lane drive enable of the data bus |
| ack_n_out | output | 1 | Acknowledge level driven on the shared pin |
| ack_oe | output | 1 | Drive enable of the shared pin |

## Verification
On every cycle, the assertions check the following relations between pins:
- data is driven only after a selected, strobed read;
- in synchronous timing the shared pin is never driven;
- an asynchronous read drives both lanes while the acknowledge is low;
- the acknowledge is released only after one high cycle, and never lingers past it.

Three things need the bench's reference model and directed scenarios: the exact clock count to the active phase, the stored and returned data, and byte merging by lane enables. The same holds for the aliasing of out-of-range addresses and for dropped short strobes, because they concern stored state seen only through later reads.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  localparam int HBI_DW    = 16;
  localparam int HBI_LANES = 2;
  localparam int HBI_LW    = HBI_DW / HBI_LANES;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_ACK  = 2'd2,
    PH_REL  = 2'd3
  } ph_t;
endpackage

// File: rtl/hbi_in_stage.sv
module hbi_in_stage
  import hbi_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 async_mode,
  input  logic                 cs_n,
  input  logic                 ds_n,
  input  logic                 rd_nwr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [HBI_DW-1:0]    din,
  input  logic                 lbe_n,
  input  logic                 hbe_n,
  output logic                 act_q,
  output logic                 mode_q,
  output logic                 rd_q,
  output logic [ADDR_W-1:0]    addr_q,
  output logic [HBI_DW-1:0]    din_q,
  output logic [HBI_LANES-1:0] lane_q
);
  logic act_raw;
  assign act_raw = !cs_n && !ds_n;

  // Access attributes are held while no access is seen, so they stay
  // stable through the release tail of an access.
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      mode_q <= 1'b0;
      rd_q   <= 1'b0;
      addr_q <= '0;
      din_q  <= '0;
      lane_q <= '0;
    end else begin
      act_q  <= act_raw;
      mode_q <= async_mode;
      if (act_raw) begin
        rd_q   <= rd_nwr;
        addr_q <= addr;
        din_q  <= din;
        lane_q <= async_mode ? {HBI_LANES{1'b1}} : ~{hbe_n, lbe_n};
      end
    end
  end
endmodule

// File: rtl/hbi_seq.sv
module hbi_seq
  import hbi_pkg::*;
#(
  parameter int ACK_DLY = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic act_q,
  input  logic rd_q,
  output ph_t  ph,
  output logic wr_fire
);
  localparam int CW = (ACK_DLY > 1) ? $clog2(ACK_DLY) : 1;
  localparam logic [CW-1:0] LAST = CW'(ACK_DLY - 1);

  logic [CW-1:0] cnt;
  logic          done;
  ph_t           ph_nx;

  assign done = (cnt == LAST);

  always_comb begin
    ph_nx = ph;
    case (ph)
      PH_IDLE: if (act_q) ph_nx = PH_WAIT;
      PH_WAIT: begin
        if (!act_q)    ph_nx = PH_IDLE;
        else if (done) ph_nx = PH_ACK;
      end
      PH_ACK:  if (!act_q) ph_nx = PH_REL;
      default: ph_nx = PH_IDLE;
    endcase
  end

  // The store happens once, on the edge that enters the active phase.
  assign wr_fire = (ph == PH_WAIT) && act_q && done && !rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else begin
      ph <= ph_nx;
      if (ph == PH_WAIT) cnt <= cnt + 1'b1;
      else               cnt <= '0;
    end
  end
endmodule

// File: rtl/hbi_regfile.sv
module hbi_regfile
  import hbi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 64
) (
  input  logic                 clk,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [HBI_DW-1:0]    wdata,
  input  logic [HBI_LANES-1:0] we,
  output logic [HBI_DW-1:0]    rdata
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             in_range;
  logic             hit_q;
  logic [IDX_W-1:0] idx;
  logic [HBI_DW-1:0] word_q;

  assign in_range = (int'(addr) < DEPTH);
  assign idx      = addr[IDX_W-1:0];

  // One narrow array per byte lane keeps each lane a plain
  // single-port RAM with a registered read.
  for (genvar g = 0; g < HBI_LANES; g++) begin : g_lane
    logic [HBI_LW-1:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (we[g] && in_range) bank[idx] <= wdata[g*HBI_LW +: HBI_LW];
      word_q[g*HBI_LW +: HBI_LW] <= bank[idx];
    end
  end

  always_ff @(posedge clk) hit_q <= in_range;

  assign rdata = hit_q ? word_q : '0;
endmodule

// File: rtl/hbi_host_port.sv
module hbi_host_port
  import hbi_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DEPTH   = 64,
  parameter int ACK_DLY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              async_mode,
  input  logic              cs_n,
  input  logic              ds_n,
  input  logic              rd_nwr,
  input  logic [15:0]       addr,
  input  logic [15:0]       din,
  input  logic              lbe_n,
  input  logic              hbe_n,
  output logic [15:0]       dout,
  output logic [1:0]        dout_oe,
  output logic              ack_n_out,
  output logic              ack_oe
);
  logic                 act_q, mode_q, rd_q, wr_fire;
  logic [ADDR_W-1:0]    addr_q;
  logic [HBI_DW-1:0]    din_q;
  logic [HBI_LANES-1:0] lane_q;
  ph_t                  ph;

  hbi_in_stage #(.ADDR_W(ADDR_W)) u_in (
    .clk(clk), .rst(rst), .async_mode(async_mode),
    .cs_n(cs_n), .ds_n(ds_n), .rd_nwr(rd_nwr),
    .addr(addr[ADDR_W-1:0]), .din(din), .lbe_n(lbe_n), .hbe_n(hbe_n),
    .act_q(act_q), .mode_q(mode_q), .rd_q(rd_q),
    .addr_q(addr_q), .din_q(din_q), .lane_q(lane_q)
  );

  hbi_seq #(.ACK_DLY(ACK_DLY)) u_seq (
    .clk(clk), .rst(rst), .act_q(act_q), .rd_q(rd_q),
    .ph(ph), .wr_fire(wr_fire)
  );

  hbi_regfile #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .addr(addr_q), .wdata(din_q),
    .we(wr_fire ? lane_q : '0), .rdata(dout)
  );

  for (genvar g = 0; g < HBI_LANES; g++) begin : g_oe
    assign dout_oe[g] = (ph == PH_ACK) && rd_q && lane_q[g];
  end

  assign ack_oe    = mode_q && ((ph == PH_ACK) || (ph == PH_REL));
  assign ack_n_out = (ph != PH_ACK);
endmodule

// File: rtl/hbi_host_port_chk.sv
module hbi_host_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       async_mode,
  input logic       cs_n,
  input logic       ds_n,
  input logic       rd_nwr,
  input logic [1:0] dout_oe,
  input logic       ack_n_out,
  input logic       ack_oe
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (dout_oe == 2'b00 && !ack_oe));

  p_drive_needs_select_r2: assert property (@(posedge clk) disable iff (rst)
    (|dout_oe) |-> $past(!cs_n && !ds_n, 2));

  p_write_no_drive_r8: assert property (@(posedge clk) disable iff (rst)
    ((|dout_oe) && $past(!cs_n && !ds_n)) |-> $past(rd_nwr));

  p_sync_ack_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    ack_oe |-> $past(async_mode));

  p_async_both_lanes_r6: assert property (@(posedge clk) disable iff (rst)
    (ack_oe && !ack_n_out && $past(!cs_n && !ds_n) && $past(rd_nwr))
      |-> (dout_oe == 2'b11));

  p_one_high_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    (ack_oe && ack_n_out) |=> !ack_oe);

  p_release_after_high_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_oe) |-> $past(ack_n_out));
endmodule

bind hbi_host_port hbi_host_port_chk u_chk (
  .clk(clk), .rst(rst), .async_mode(async_mode), .cs_n(cs_n), .ds_n(ds_n),
  .rd_nwr(rd_nwr), .dout_oe(dout_oe), .ack_n_out(ack_n_out), .ack_oe(ack_oe)
);

// File: tb/tb_hbi_host_port.sv
module tb_hbi_host_port;
  localparam int CLK_P   = 10;
  localparam int ACK_DLY = 3;
  localparam int DEPTH   = 64;

  logic clk = 1'b0, rst = 1'b1, async_mode = 1'b1;
  logic cs_n = 1'b1, ds_n = 1'b1, rd_nwr = 1'b1, lbe_n = 1'b0, hbe_n = 1'b0;
  logic [15:0] addr = '0, din = '0, dout;
  logic [1:0]  dout_oe;
  logic        ack_n_out, ack_oe;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  hbi_host_port #(.ADDR_W(16), .DEPTH(DEPTH), .ACK_DLY(ACK_DLY)) dut (
    .clk(clk), .rst(rst), .async_mode(async_mode), .cs_n(cs_n), .ds_n(ds_n),
    .rd_nwr(rd_nwr), .addr(addr), .din(din), .lbe_n(lbe_n), .hbe_n(hbe_n),
    .dout(dout), .dout_oe(dout_oe), .ack_n_out(ack_n_out), .ack_oe(ack_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: phases as integers, memory as associative array.
  logic [15:0] mm [int];
  int   m_ph = 0, m_cnt = 0;
  bit   m_act = 0, m_mode = 0, m_rd = 0;
  int   m_addr = 0;
  logic [15:0] m_din = '0, m_word = '0;
  logic [1:0]  m_lane = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_cnt = 0; m_act = 0; m_mode = 0; m_rd = 0;
      m_addr = 0; m_din = '0; m_lane = '0;
    end else begin
      if (m_addr < DEPTH) m_word = mm.exists(m_addr) ? mm[m_addr] : 16'hxxxx;
      else                m_word = 16'h0000;
      case (m_ph)
        0: if (m_act) begin m_ph = 1; m_cnt = 0; end
        1: if (!m_act) m_ph = 0;
           else if (m_cnt == ACK_DLY-1) begin
             m_ph = 2;
             if (!m_rd && m_addr < DEPTH) begin
               logic [15:0] w;
               w = mm.exists(m_addr) ? mm[m_addr] : 16'h0000;
               if (m_lane[0]) w[7:0]  = m_din[7:0];
               if (m_lane[1]) w[15:8] = m_din[15:8];
               mm[m_addr] = w;
             end
           end else m_cnt++;
        2: if (!m_act) m_ph = 3;
        default: m_ph = 0;
      endcase
      m_act  = !cs_n && !ds_n;
      m_mode = async_mode;
      if (m_act) begin
        m_rd = rd_nwr; m_addr = int'(addr); m_din = din;
        m_lane = async_mode ? 2'b11 : {!hbe_n, !lbe_n};
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [1:0] e_oe;
      bit e_aoe;
      e_oe[0] = (m_ph == 2) && m_rd && m_lane[0];
      e_oe[1] = (m_ph == 2) && m_rd && m_lane[1];
      e_aoe   = m_mode && (m_ph == 2 || m_ph == 3);
      chk(dout_oe === e_oe, "R4 lane drive", 32'(dout_oe), 32'(e_oe));
      chk(ack_oe === e_aoe, "R6 ack drive", 32'(ack_oe), 32'(e_aoe));
      if (e_aoe)
        chk(ack_n_out === (m_ph == 3), "R7 ack level", 32'(ack_n_out), 32'(m_ph == 3));
      for (int b = 0; b < 2; b++)
        if (e_oe[b] && !$isunknown(m_word[b*8 +: 8]))
          chk(dout[b*8 +: 8] === m_word[b*8 +: 8], "R4 read data",
              32'(dout[b*8 +: 8]), 32'(m_word[b*8 +: 8]));
    end
  end

  // One host access; hold = negedges that select and strobe stay low.
  task automatic access(input bit rd, input logic [15:0] a, input logic [15:0] d,
                        input logic [1:0] be_n, input int hold,
                        output logic [15:0] q);
    bit full;
    full = (hold >= ACK_DLY + 3);
    q = 'x;
    @(negedge clk);
    cs_n = 0; ds_n = 0; rd_nwr = rd; addr = a; din = d;
    lbe_n = be_n[0]; hbe_n = be_n[1];
    for (int i = 1; i <= hold; i++) begin
      @(negedge clk);
      if (i == ACK_DLY + 1)
        chk(dout_oe == 2'b00 && !ack_oe, "R3 not early", {dout_oe, ack_oe}, 0);
      if (i == ACK_DLY + 2) begin
        if (async_mode)
          chk(ack_oe && !ack_n_out, "R3 ack on time", {ack_oe, ack_n_out}, 2'b10);
        if (!rd) chk(dout_oe == 2'b00, "R8 write no drive", dout_oe, 0);
        if (!async_mode) chk(!ack_oe, "R8 sync no ack", ack_oe, 0);
        q = dout;
      end
    end
    cs_n = 1; ds_n = 1;
    @(negedge clk);
    @(negedge clk);
    if (async_mode && full)
      chk(ack_oe && ack_n_out, "R7 high before release", {ack_oe, ack_n_out}, 2'b11);
    @(negedge clk);
    chk(!ack_oe && dout_oe == 2'b00, "R7 released", {dout_oe, ack_oe}, 0);
    @(negedge clk);
  endtask

  localparam int FULL = ACK_DLY + 3;

  initial begin
    logic [15:0] q;
    repeat (3) @(negedge clk);
    chk(dout_oe == 2'b00 && !ack_oe, "R1 in reset", {dout_oe, ack_oe}, 0);
    rst = 0;
    @(negedge clk);
    chk(dout_oe == 2'b00 && !ack_oe, "R1 after reset", {dout_oe, ack_oe}, 0);

    access(0, 16'd5, 16'hA5C3, 2'b00, FULL, q);
    access(1, 16'd5, 16'h0000, 2'b00, FULL, q);
    chk(q == 16'hA5C3, "R11 readback", q, 16'hA5C3);
    access(1, 16'h8000, 16'h0, 2'b00, FULL, q);
    chk(q == 16'h0000, "R9 out of range reads zero", q, 0);
    access(0, 16'h0045, 16'h1111, 2'b00, FULL, q);
    access(1, 16'd5, 16'h0, 2'b00, FULL, q);
    chk(q == 16'hA5C3, "R9 alias write ignored", q, 16'hA5C3);

    // R2: select without strobe, strobe without select
    @(negedge clk); cs_n = 0; ds_n = 1; rd_nwr = 0; addr = 16'd5; din = 16'h0000;
    repeat (8) @(negedge clk);
    chk(!ack_oe, "R2 no strobe no ack", ack_oe, 0);
    cs_n = 1; ds_n = 0;
    repeat (8) @(negedge clk);
    chk(!ack_oe, "R2 no select no ack", ack_oe, 0);
    ds_n = 1; repeat (2) @(negedge clk);
    access(1, 16'd5, 16'h0, 2'b00, FULL, q);
    chk(q == 16'hA5C3, "R2 no write stored", q, 16'hA5C3);

    // R10: short strobe dropped
    access(0, 16'd9, 16'h0F0F, 2'b00, FULL, q);
    access(0, 16'd9, 16'hFFFF, 2'b00, 2, q);
    access(1, 16'd9, 16'h0, 2'b00, FULL, q);
    chk(q == 16'h0F0F, "R10 aborted write", q, 16'h0F0F);

    // Synchronous timing with byte lanes
    @(negedge clk); async_mode = 0; repeat (3) @(negedge clk);
    access(0, 16'd5, 16'h1234, 2'b10, FULL, q);
    access(1, 16'd5, 16'h0, 2'b00, FULL, q);
    chk(q == 16'hA534, "R5 low lane write", q, 16'hA534);
    access(0, 16'd5, 16'h7700, 2'b01, FULL, q);
    @(negedge clk);
    cs_n = 0; ds_n = 0; rd_nwr = 1; addr = 16'd5; lbe_n = 1; hbe_n = 0;
    repeat (ACK_DLY + 2) @(negedge clk);
    chk(dout_oe == 2'b10, "R5 high lane only", dout_oe, 2'b10);
    chk(dout[15:8] == 8'h77, "R5 high lane data", dout[15:8], 8'h77);
    chk(!ack_oe, "R8 sync ack quiet", ack_oe, 0);
    cs_n = 1; ds_n = 1; repeat (4) @(negedge clk);
    access(1, 16'd5, 16'h0, 2'b00, FULL, q);
    chk(q == 16'h7734, "R5 merged word", q, 16'h7734);

    // Back to asynchronous timing: lane enables no longer matter
    async_mode = 1; repeat (3) @(negedge clk);
    access(1, 16'd9, 16'h0, 2'b11, FULL, q);
    chk(q == 16'h0F0F, "R6 both lanes in async", q, 16'h0F0F);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule